// File: doc/BRIEF.md
# Configurable Serial Audio Receiver

This block is the receive side of a synchronous serial audio port. It watches a bit-clock sampling strobe, a frame-sync level and a serial data line. On every strobe that arrives while frame sync is high, one data bit is taken into a shift register. Once the number of bits set by the slot-length select has arrived, the word is moved into a 24-bit data register that can only be read. The word is placed according to an alignment control. A data-full flag rises, and with it an interrupt if that interrupt is enabled.

The serial side runs on the system clock. `bitTick` is a one-cycle pulse that marks each bit-clock sampling point, so the clock and frame-sync generators upstream decide the rate. Software reads the word through `dataRd` and reads status through `statusRd`. When a word completes before the previous one was read, a sticky overrun flag is set and the new word replaces the old one.

Top module: `serial_audio_rx`

## Requirements
- R1: After reset `rxData` is 0, and `rxFull`, `rxOverrun` and `rxIrq` are all 0.
- R2: A bit is taken only on a clock edge where both `bitTick` and `frameSync` are 1. A `bitTick` seen with `frameSync` at 0 takes no bit and throws away any partly received word, so the next bit taken starts a new word.
- R3: `slotSel` codes 0, 1, 2, 3, 4 and 5 select words of 8, 12, 16, 20, 24 and 32 bits. Codes 6 and 7 behave as 24 bits. The word is transferred on the same clock edge that takes its last bit.
- R4: With `lsbFirst` at 0 the first bit received is the most significant bit of the word. With `lsbFirst` at 1 it is the least significant bit.
- R5: With `align16` at 0 the word's most significant bit lands on `rxData` bit 23 and all unused low bits are 0. For a 32-bit slot only the 24 most significant received bits are kept.
- R6: With `align16` at 1 `rxData[23:16]` is 0 and the word's most significant bit lands on bit 15. Unused low bits are 0, words wider than 16 bits keep their top 16 bits, and an 8-bit word sits in bits 15:8.
- R7: `rxFull` is set by a transfer. A `dataRd` pulse clears it unless a transfer happens on the same edge, in which case it stays set.
- R8: `rxIrq` equals `rxFull` AND `rxIntEn` at all times.
- R9: A transfer while `rxFull` is 1 and `dataRd` is 0 sets `rxOverrun`, which stays set. The new word still replaces the old one.
- R10: `rxOverrun` is cleared only by a `dataRd` pulse after a `statusRd` pulse seen in an earlier cycle while `rxOverrun` was 1. A `dataRd` pulse without that earlier status read leaves it set.
- R11: `rxData` changes only on a transfer. Read pulses never alter it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bitTick | input | 1 | One-cycle bit-clock sampling strobe |
| frameSync | input | 1 | Frame-sync level that gates reception |
| serialIn | input | 1 | Serial data line |
| slotSel | input | 3 | Slot-length select (0..5 = 8,12,16,20,24,32 bits) |
| lsbFirst | input | 1 | 1 = least significant bit first |
| align16 | input | 1 | 1 = align word to bit 15, top byte zero |
| rxIntEn | input | 1 | Receive-full interrupt enable |
| statusRd | input | 1 | Status read pulse (arms overrun clear) |
| dataRd | input | 1 | Data register read pulse |
| rxData | output | 24 | Received word, aligned |
| rxFull | output | 1 | Data-full flag |
| rxOverrun | output | 1 | Sticky overrun flag |
| rxIrq | output | 1 | Receive interrupt |

## Verification
On every cycle the assertions check the following. A transfer always leaves `rxFull` set. `rxOverrun` only rises while a word was already waiting, and it only falls on a data read. `rxData` holds between transfers. The top byte is zero after any transfer made in 16-bit alignment. The bench's scenarios are needed for the rest. They show the actual bit order and placement of each slot length in both directions and both alignments. They also show the discard of a word cut short by frame sync, the status-then-data sequence that clears overrun, and a read that lands on the same edge as a transfer.

// File: rtl/sarx_pkg.sv
package sarx_pkg;
  localparam int SHIFT_W  = 32;
  localparam int DATA_W   = 24;
  localparam int NARROW_W = 16;
  localparam int CNT_W    = $clog2(SHIFT_W);
  localparam int LEN_W    = CNT_W + 1;

  // strobes from the control to the datapath
  typedef struct packed {
    logic shiftEn;
    logic capture;
  } rx_strobe_t;

  // slot length in bits for a select code; unused codes fall back to 24
  function automatic logic [LEN_W-1:0] slotBits(input logic [2:0] sel);
    logic [LEN_W-1:0] len;
    case (sel)
      3'd0:    len = LEN_W'(8);
      3'd1:    len = LEN_W'(12);
      3'd2:    len = LEN_W'(16);
      3'd3:    len = LEN_W'(20);
      3'd4:    len = LEN_W'(24);
      3'd5:    len = LEN_W'(32);
      default: len = LEN_W'(24);
    endcase
    return len;
  endfunction
endpackage

// File: rtl/sarx_ctrl.sv
module sarx_ctrl
  import sarx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitTick,
  input  logic       frameSync,
  input  logic [2:0] slotSel,
  input  logic       statusRd,
  input  logic       dataRd,
  output rx_strobe_t strb,
  output logic       rxFull,
  output logic       rxOverrun
);
  logic [CNT_W-1:0] bitCntQ;
  logic [LEN_W-1:0] slotLen;
  logic             lastBit;
  logic             armedQ;
  logic             setOvr;
  logic             clrOvr;

  assign slotLen      = slotBits(slotSel);
  // a shortened slot mid-word still terminates instead of wrapping
  assign lastBit      = ({1'b0, bitCntQ} >= (slotLen - LEN_W'(1)));
  assign strb.shiftEn = bitTick & frameSync;
  assign strb.capture = strb.shiftEn & lastBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCntQ <= '0;
    end else if (bitTick && !frameSync) begin
      bitCntQ <= '0;
    end else if (strb.capture) begin
      bitCntQ <= '0;
    end else if (strb.shiftEn) begin
      bitCntQ <= bitCntQ + CNT_W'(1);
    end
  end

  assign setOvr = strb.capture & rxFull & ~dataRd;
  assign clrOvr = dataRd & armedQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxFull    <= 1'b0;
      rxOverrun <= 1'b0;
      armedQ    <= 1'b0;
    end else begin
      if (strb.capture)  rxFull <= 1'b1;
      else if (dataRd)   rxFull <= 1'b0;

      if (setOvr)        rxOverrun <= 1'b1;
      else if (clrOvr)   rxOverrun <= 1'b0;

      if (dataRd)                     armedQ <= 1'b0;
      else if (statusRd && rxOverrun) armedQ <= 1'b1;
    end
  end

  // R7
  full_after_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> rxFull);

  // R9
  ovr_needs_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxOverrun) |-> $past(rxFull));

  // R10
  ovr_clear_on_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rxOverrun) |-> $past(dataRd));
endmodule

// File: rtl/sarx_datapath.sv
module sarx_datapath
  import sarx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  rx_strobe_t        strb,
  input  logic              serialIn,
  input  logic [2:0]        slotSel,
  input  logic              lsbFirst,
  input  logic              align16,
  output logic [DATA_W-1:0] rxData
);
  localparam int PAD_HI = DATA_W - NARROW_W;

  logic [SHIFT_W-1:0] shiftQ;
  logic [SHIFT_W-1:0] shiftD;
  logic [SHIFT_W-1:0] keepMask;
  logic [SHIFT_W-1:0] leftAligned;
  logic [DATA_W-1:0]  packedWord;
  logic [LEN_W-1:0]   padBits;

  assign padBits  = LEN_W'(SHIFT_W) - slotBits(slotSel);
  assign keepMask = {SHIFT_W{1'b1}} << padBits;

  // MSB-first fills from the bottom, LSB-first fills from the top
  assign shiftD = lsbFirst ? {serialIn, shiftQ[SHIFT_W-1:1]}
                           : {shiftQ[SHIFT_W-2:0], serialIn};

  // bring the word's MSB to the top of the shift width, clear the rest
  assign leftAligned = lsbFirst ? (shiftD & keepMask) : (shiftD << padBits);

  assign packedWord = align16
                    ? {{PAD_HI{1'b0}}, leftAligned[SHIFT_W-1 -: NARROW_W]}
                    : leftAligned[SHIFT_W-1 -: DATA_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ <= '0;
      rxData <= '0;
    end else begin
      if (strb.shiftEn) shiftQ <= shiftD;
      if (strb.capture) rxData <= packedWord;
    end
  end

  // R11
  data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> $stable(rxData));

  // R6
  top_byte_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && align16) |=> (rxData[DATA_W-1 -: PAD_HI] == '0));
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import sarx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitTick,
  input  logic              frameSync,
  input  logic              serialIn,
  input  logic [2:0]        slotSel,
  input  logic              lsbFirst,
  input  logic              align16,
  input  logic              rxIntEn,
  input  logic              statusRd,
  input  logic              dataRd,
  output logic [DATA_W-1:0] rxData,
  output logic              rxFull,
  output logic              rxOverrun,
  output logic              rxIrq
);
  rx_strobe_t strb;

  sarx_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .bitTick   (bitTick),
    .frameSync (frameSync),
    .slotSel   (slotSel),
    .statusRd  (statusRd),
    .dataRd    (dataRd),
    .strb      (strb),
    .rxFull    (rxFull),
    .rxOverrun (rxOverrun)
  );

  sarx_datapath i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .serialIn (serialIn),
    .slotSel  (slotSel),
    .lsbFirst (lsbFirst),
    .align16  (align16),
    .rxData   (rxData)
  );

  assign rxIrq = rxFull & rxIntEn;

  // R8
  irq_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |-> (rxFull && rxIntEn));
endmodule

// File: tb/test_serial_audio_rx.sv
module test_serial_audio_rx;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bitTick = 1'b0, frameSync = 1'b0, serialIn = 1'b0;
  logic [2:0]  slotSel = 3'd0;
  logic        lsbFirst = 1'b0, align16 = 1'b0, rxIntEn = 1'b0;
  logic        statusRd = 1'b0, dataRd = 1'b0;
  logic [23:0] rxData;
  logic        rxFull, rxOverrun, rxIrq;
  int          nChecks = 0, nErrors = 0;
  logic        done = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  serial_audio_rx i_serial_audio_rx (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .frameSync(frameSync),
    .serialIn(serialIn), .slotSel(slotSel), .lsbFirst(lsbFirst),
    .align16(align16), .rxIntEn(rxIntEn), .statusRd(statusRd),
    .dataRd(dataRd), .rxData(rxData), .rxFull(rxFull),
    .rxOverrun(rxOverrun), .rxIrq(rxIrq)
  );

  function automatic int lenOf(input logic [2:0] sel);
    case (sel)
      3'd0: return 8;   3'd1: return 12;  3'd2: return 16;
      3'd3: return 20;  3'd5: return 32;  default: return 24;
    endcase
  endfunction

  function automatic logic [23:0] expWord(input logic [31:0] v, input int n,
                                          input logic al);
    logic [31:0] m, top;
    m   = (n == 32) ? v : (v & ((32'd1 << n) - 32'd1));
    top = m << (32 - n);
    return al ? {8'h00, top[31:16]} : top[31:8];
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                     input string req);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input logic fs, input logic b, input logic rd);
    @(negedge clk);
    bitTick = 1'b1; frameSync = fs; serialIn = b; dataRd = rd;
    @(negedge clk);
    bitTick = 1'b0; dataRd = 1'b0;
  endtask

  task automatic sendWord(input logic [31:0] v, input int n,
                          input logic rdOnLast);
    for (int i = 0; i < n; i++) begin
      automatic logic b = lsbFirst ? v[i] : v[n-1-i];
      tick(1'b1, b, rdOnLast && (i == n - 1));
    end
  endtask

  task automatic pulseData();
    @(negedge clk); dataRd = 1'b1;
    @(negedge clk); dataRd = 1'b0;
  endtask

  task automatic pulseStatus();
    @(negedge clk); statusRd = 1'b1;
    @(negedge clk); statusRd = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++; nErrors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(rxData, 0, "R1"); chk(rxFull, 0, "R1");
    chk(rxOverrun, 0, "R1"); chk(rxIrq, 0, "R1");
    rstN = 1'b1;
    @(negedge clk);

    // directed: every slot length, both orders, both alignments
    for (int s = 0; s < 8; s++) begin
      for (int k = 0; k < 4; k++) begin
        automatic logic [31:0] v = $urandom();
        slotSel = 3'(s); lsbFirst = k[0]; align16 = k[1];
        sendWord(v, lenOf(3'(s)), 1'b0);
        chk(rxData, expWord(v, lenOf(3'(s)), align16),
            align16 ? "R6 R3 R4" : "R5 R3 R4");
        chk(rxFull, 1, "R7");
        pulseData();
        chk(rxFull, 0, "R7");
      end
    end

    // R6: 8-bit word sits in 15:8
    slotSel = 3'd0; lsbFirst = 1'b0; align16 = 1'b1;
    sendWord(32'hA5, 8, 1'b0);
    chk(rxData, 24'h00A500, "R6");
    pulseData();
    // R5: 32-bit slot keeps top 24 bits
    slotSel = 3'd5; align16 = 1'b0;
    sendWord(32'h12345678, 32, 1'b0);
    chk(rxData, 24'h123456, "R5");
    pulseData();

    // R2: frame-sync drop discards partial word; ticks without sync ignored
    slotSel = 3'd0;
    for (int i = 0; i < 5; i++) tick(1'b1, 1'b1, 1'b0);
    tick(1'b0, 1'b1, 1'b0);
    chk(rxFull, 0, "R2");
    for (int i = 0; i < 10; i++) tick(1'b0, 1'b1, 1'b0);
    chk(rxFull, 0, "R2");
    chk(rxData, 24'h123456, "R2 R11");
    sendWord(32'h3C, 8, 1'b0);
    chk(rxData, 24'h3C0000, "R2");

    // R8 interrupt follows enable
    chk(rxIrq, 0, "R8");
    @(negedge clk); rxIntEn = 1'b1; #1;
    chk(rxIrq, 1, "R8");

    // R9 overrun: second word while full
    sendWord(32'h81, 8, 1'b0);
    chk(rxOverrun, 1, "R9"); chk(rxData, 24'h810000, "R9");
    chk(rxFull, 1, "R9");
    // R10 data read alone does not clear
    pulseData();
    chk(rxOverrun, 1, "R10"); chk(rxFull, 0, "R7");
    chk(rxIrq, 0, "R8");
    chk(rxData, 24'h810000, "R11");
    // R10 status read then data read clears
    pulseStatus();
    chk(rxOverrun, 1, "R10");
    pulseData();
    chk(rxOverrun, 0, "R10");

    // R7/R9: read on the transfer edge keeps full, no overrun
    sendWord(32'h11, 8, 1'b0);
    sendWord(32'h22, 8, 1'b1);
    chk(rxFull, 1, "R7"); chk(rxOverrun, 0, "R9");
    chk(rxData, 24'h220000, "R7");
    pulseData();

    // constrained random words
    for (int t = 0; t < 40; t++) begin
      automatic logic [31:0] v = $urandom();
      automatic int n;
      slotSel = 3'($urandom_range(0, 7));
      lsbFirst = 1'($urandom()); align16 = 1'($urandom());
      rxIntEn = 1'($urandom());
      n = lenOf(slotSel);
      sendWord(v, n, 1'b0);
      chk(rxData, expWord(v, n, align16), "R3 R4 R5 R6");
      chk(rxIrq, rxIntEn, "R8");
      pulseData();
      chk(rxFull, 0, "R7");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end
endmodule